// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Register Unit

This unit keeps the interrupt-cause register, the status register and the first configuration register of a SCSI protocol controller. It also drives the controller's single level-sensitive interrupt line. The surrounding sequencer logic feeds it three kinds of input: one-cycle cause pulses (bus service, function complete, disconnect), a phase code with a load strobe, and terminal-count set and clear events. The command decoder feeds it two pulses, one for the bus-reset command and one for the chip-reset command.

Software reaches the registers through a byte-wide read port. Reading the interrupt register clears it and releases the interrupt line, so a handler sees each batch of causes exactly once. That same read wipes the transient status flags. The terminal-count flag and the bus phase survive the read, so the handler can still tell which phase the bus is in and whether the count ran out.

The read data is combinational from the selected register whether or not a read is strobed. Only a strobed read of the interrupt register has a side effect, and that side effect lands on the next clock edge.

Top module: `scsi_irq_status_unit`

## Requirements
- R1: Any cause in a cycle sets the pending bit (status bit 7) and drives `irq` high from the next cycle. A cause is a non-zero `cause_in` or a reported bus reset. The bit and `irq` stay high until a clear-on-read or a reset.
- R2: The interrupt register has bus service in bit 0, function complete in bit 1, disconnect in bit 2 and bus reset in bit 3. Bits 2:0 of `cause_in` OR into bits 2:0 and gather across cycles until they are cleared.
- R3: `rd_sel` selects the register: 0 = interrupt, 1 = status, 2 = configuration, 3 = reads as zero. A read with `rd_en` high and `rd_sel`=0 returns the current interrupt register on `rd_data` in that cycle. From the next cycle the interrupt register reads 0 and `irq` is low.
- R4: The status register has the phase in bits 2:0, terminal count in bit 4, the error flag in bit 6 and pending in bit 7. Bits 3 and 5 read 0. `err_set` sets the error flag. The interrupt-register read clears the error and pending bits and keeps the terminal-count bit and the phase.
- R5: `phase_set` loads `phase_code` into status bits 2:0 and changes no other status bit. The codes are data-out 0, data-in 1, command 2, status 3, message-out 6, message-in 7; codes 4 and 5 are reserved but stored as given.
- R6: `tc_hit` sets status bit 4 and `tc_clr` clears it. When both arrive in the same cycle, the bit ends up set. Neither input raises the interrupt.
- R7: `bus_rst_cmd` sets interrupt bit 3 and raises the interrupt only when configuration bit 6 (report-disable) is 0 in the value held before that cycle. When that bit is 1, the command changes neither the interrupt register nor `irq`.
- R8: `rst` clears the interrupt, status and pending state, lowers `irq` and loads the configuration register with 8'h07. `soft_rst_cmd` has the same effect on the next edge and overrides every other input of that cycle.
- R9: When a new cause or `err_set` arrives in the same cycle as the clear-on-read, the new bits and the pending bit are present after the read. No event is lost.
- R10: `cfg_we` writes `cfg_wdata` into the configuration register. With `rd_en` low, or with `rd_sel` not 0, `rd_data` still shows the selected register and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| phase_set | input | 1 | Load strobe for the bus phase |
| phase_code | input | 3 | New bus phase code |
| cause_in | input | 3 | Cause pulses: bit0 bus service, bit1 function complete, bit2 disconnect |
| err_set | input | 1 | Sets the status error flag |
| tc_hit | input | 1 | Terminal-count reached event |
| tc_clr | input | 1 | Clears the terminal-count flag (count reloaded) |
| bus_rst_cmd | input | 1 | Bus-reset command pulse |
| soft_rst_cmd | input | 1 | Chip-reset command pulse |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| rd_en | input | 1 | Read strobe (side effect only when rd_sel is 0) |
| rd_sel | input | 2 | Register select for rd_data |
| rd_data | output | 8 | Selected register value |
| irq | output | 1 | Level interrupt output |

## Verification
Assertions check several properties on every clock:
- any cause sets the pending bit, and the bit holds until it is cleared;
- a cause-free clear-on-read empties the interrupt register;
- a cause that collides with the read survives it;
- the phase changes only on its strobe, and the terminal-count bit follows its hit input;
- the configuration register holds unless written;
- a suppressed bus reset leaves interrupt bit 3 alone.

Other behaviour shows only in the bench's scenarios, which a cycle-accurate reference model compares on every clock. These scenarios include:
- the exact bit layout of both registers as seen through the read port;
- the use of the previously held report-disable bit when it is written in the same cycle as a bus reset;
- the override by a chip-reset command;
- a set and clear of terminal count arriving together.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int REG_W      = 8;
    localparam int CAUSE_W    = 4;
    localparam int PHASE_W    = 3;
    localparam int SRC_W      = CAUSE_W - 1;

    // interrupt register bit positions
    localparam int IB_BSVC    = 0;
    localparam int IB_FDONE   = 1;
    localparam int IB_DISC    = 2;
    localparam int IB_BRST    = 3;

    // status register bit positions
    localparam int SB_TC      = 4;
    localparam int SB_ERR     = 6;
    localparam int SB_PEND    = 7;

    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_DOUT = 3'd0,
        PH_DIN  = 3'd1,
        PH_CMD  = 3'd2,
        PH_STS  = 3'd3,
        PH_RSV4 = 3'd4,
        PH_RSV5 = 3'd5,
        PH_MOUT = 3'd6,
        PH_MIN  = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        SEL_INT  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } rsel_e;

    typedef struct packed {
        logic   pend;
        logic   err;
        logic   tc;
        phase_e phase;
    } stat_t;

    function automatic reg_t pack_status(input stat_t s);
        reg_t r;
        r           = '0;
        r[PHASE_W-1:0] = s.phase;
        r[SB_TC]    = s.tc;
        r[SB_ERR]   = s.err;
        r[SB_PEND]  = s.pend;
        return r;
    endfunction

    function automatic reg_t widen_cause(input cause_t c);
        reg_t r;
        r = '0;
        r[CAUSE_W-1:0] = c;
        return r;
    endfunction

endpackage

// File: rtl/sirq_cause_reg.sv
module sirq_cause_reg
    import sirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   soft_rst_i,
    input  cause_t cause_i,
    input  logic   rd_clr_i,
    output cause_t int_o,
    output logic   pend_o
);

    cause_t int_q;
    logic   pend_q;
    cause_t int_base;
    logic   pend_base;

    always_comb begin
        int_base  = rd_clr_i ? '0   : int_q;
        pend_base = rd_clr_i ? 1'b0 : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            int_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            int_q  <= int_base | cause_i;
            pend_q <= pend_base | (|cause_i);
        end
    end

    assign int_o  = int_q;
    assign pend_o = pend_q;

    AST_CAUSE_RAISES: assert property (@(posedge clk) disable iff (rst)
        ((|cause_i) && !soft_rst_i) |=> pend_o); // R1

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !rd_clr_i && !soft_rst_i) |=> pend_o); // R1

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && (cause_i == '0) && !soft_rst_i) |=> (int_o == '0 && !pend_o)); // R3

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && (|cause_i) && !soft_rst_i)
        |=> (((int_o & $past(cause_i)) == $past(cause_i)) && pend_o)); // R9

endmodule

// File: rtl/sirq_stat_reg.sv
module sirq_stat_reg
    import sirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst_i,
    input  logic               rd_clr_i,
    input  logic               phase_we_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               tc_hit_i,
    input  logic               tc_clr_i,
    input  logic               err_set_i,
    output phase_e             phase_o,
    output logic               tc_o,
    output logic               err_o
);

    phase_e phase_q;
    logic   tc_q;
    logic   err_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            phase_q <= PH_DOUT;
            tc_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (phase_we_i) begin
                phase_q <= phase_e'(phase_i);
            end
            if (tc_hit_i) begin
                tc_q <= 1'b1;
            end else if (tc_clr_i) begin
                tc_q <= 1'b0;
            end
            err_q <= (err_q && !rd_clr_i) || err_set_i;
        end
    end

    assign phase_o = phase_q;
    assign tc_o    = tc_q;
    assign err_o   = err_q;

    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (phase_we_i && !soft_rst_i) |=> (phase_o == $past(phase_i))); // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!phase_we_i && !soft_rst_i) |=> $stable(phase_o)); // R4

    AST_TC_SET: assert property (@(posedge clk) disable iff (rst)
        (tc_hit_i && !soft_rst_i) |=> tc_o); // R6

    AST_TC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (tc_o && !tc_clr_i && !soft_rst_i) |=> tc_o); // R4

    AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !err_set_i) |=> !err_o); // R4

endmodule

// File: rtl/sirq_cfg_reg.sv
module sirq_cfg_reg
    import sirq_pkg::*;
#(
    parameter reg_t CFG_RESET   = 8'h07,
    parameter int   RPT_OFF_BIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst_i,
    input  logic we_i,
    input  reg_t wdata_i,
    output reg_t cfg_o,
    output logic rpt_off_o
);

    reg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            cfg_q <= CFG_RESET;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    assign cfg_o     = cfg_q;
    assign rpt_off_o = cfg_q[RPT_OFF_BIT];

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we_i && !soft_rst_i) |=> $stable(cfg_o)); // R10

    AST_CFG_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (cfg_o == CFG_RESET)); // R8

endmodule

// File: rtl/scsi_irq_status_unit.sv
module scsi_irq_status_unit
    import sirq_pkg::*;
#(
    parameter logic [7:0] CFG_RESET   = 8'h07,
    parameter int         RPT_OFF_BIT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       phase_set,
    input  logic [2:0] phase_code,
    input  logic [2:0] cause_in,
    input  logic       err_set,
    input  logic       tc_hit,
    input  logic       tc_clr,
    input  logic       bus_rst_cmd,
    input  logic       soft_rst_cmd,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       rd_en,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       irq
);

    cause_t int_val;
    logic   pend;
    phase_e phase;
    logic   tc_flag;
    logic   err_flag;
    reg_t   cfg_val;
    logic   rpt_off;
    logic   rd_clr;
    logic   brst_report;
    cause_t cause_vec;
    stat_t  stat_view;

    assign rd_clr      = rd_en && (rsel_e'(rd_sel) == SEL_INT);
    assign brst_report = bus_rst_cmd && !rpt_off;

    always_comb begin
        cause_vec                 = '0;
        cause_vec[SRC_W-1:0]      = cause_in;
        cause_vec[IB_BRST]        = brst_report;
    end

    sirq_cause_reg u_cause (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_cmd),
        .cause_i    (cause_vec),
        .rd_clr_i   (rd_clr),
        .int_o      (int_val),
        .pend_o     (pend)
    );

    sirq_stat_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_cmd),
        .rd_clr_i   (rd_clr),
        .phase_we_i (phase_set),
        .phase_i    (phase_code),
        .tc_hit_i   (tc_hit),
        .tc_clr_i   (tc_clr),
        .err_set_i  (err_set),
        .phase_o    (phase),
        .tc_o       (tc_flag),
        .err_o      (err_flag)
    );

    sirq_cfg_reg #(
        .CFG_RESET   (CFG_RESET),
        .RPT_OFF_BIT (RPT_OFF_BIT)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .soft_rst_i (soft_rst_cmd),
        .we_i       (cfg_we),
        .wdata_i    (cfg_wdata),
        .cfg_o      (cfg_val),
        .rpt_off_o  (rpt_off)
    );

    always_comb begin
        stat_view.pend  = pend;
        stat_view.err   = err_flag;
        stat_view.tc    = tc_flag;
        stat_view.phase = phase;
        unique case (rsel_e'(rd_sel))
            SEL_INT:  rd_data = widen_cause(int_val);
            SEL_STAT: rd_data = pack_status(stat_view);
            SEL_CFG:  rd_data = cfg_val;
            default:  rd_data = '0;
        endcase
    end

    assign irq = pend;

    AST_BRST_MUTED: assert property (@(posedge clk) disable iff (rst)
        (bus_rst_cmd && rpt_off && !rd_clr && !soft_rst_cmd)
        |=> $stable(int_val[IB_BRST])); // R7

    AST_BRST_SHOWN: assert property (@(posedge clk) disable iff (rst)
        (bus_rst_cmd && !rpt_off && !soft_rst_cmd)
        |=> (int_val[IB_BRST] && irq)); // R7

endmodule

// File: tb/scsi_irq_status_unit_tb_top.sv
module scsi_irq_status_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       phase_set;
    logic [2:0] phase_code;
    logic [2:0] cause_in;
    logic       err_set;
    logic       tc_hit;
    logic       tc_clr;
    logic       bus_rst_cmd;
    logic       soft_rst_cmd;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       rd_en;
    logic [1:0] rd_sel;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_int, m_pend, m_err, m_tc, m_ph, m_cfg;

    always #10 clk = ~clk;

    scsi_irq_status_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .phase_set    (phase_set),
        .phase_code   (phase_code),
        .cause_in     (cause_in),
        .err_set      (err_set),
        .tc_hit       (tc_hit),
        .tc_clr       (tc_clr),
        .bus_rst_cmd  (bus_rst_cmd),
        .soft_rst_cmd (soft_rst_cmd),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .irq          (irq)
    );

    function automatic int exp_rd(input int sel);
        case (sel)
            0: return m_int;
            1: return (m_pend << 7) | (m_err << 6) | (m_tc << 4) | m_ph;
            2: return m_cfg;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clr_in();
        rst = 0; phase_set = 0; phase_code = 0; cause_in = 0; err_set = 0;
        tc_hit = 0; tc_clr = 0; bus_rst_cmd = 0; soft_rst_cmd = 0;
        cfg_we = 0; cfg_wdata = 0; rd_en = 0; rd_sel = 0;
    endtask

    // compare outputs, clock once, advance the model
    task automatic cyc(input string tag);
        int newc, rclr;
        #1;
        check(tag, int'(rd_data), exp_rd(int'(rd_sel)), "rd_data");
        check(tag, int'(irq), m_pend, "irq");
        @(posedge clk);
        if (rst || soft_rst_cmd) begin
            m_int = 0; m_pend = 0; m_err = 0; m_tc = 0; m_ph = 0; m_cfg = 7;
        end else begin
            rclr = (rd_en && rd_sel == 0) ? 1 : 0;
            newc = int'(cause_in) | ((bus_rst_cmd && !m_cfg[6]) ? 8 : 0);
            m_int  = (rclr ? 0 : m_int) | newc;
            m_pend = ((rclr ? 0 : m_pend) | (newc != 0)) ? 1 : 0;
            m_err  = ((rclr ? 0 : m_err) | err_set) ? 1 : 0;
            if (tc_hit) m_tc = 1; else if (tc_clr) m_tc = 0;
            if (phase_set) m_ph = int'(phase_code);
            if (cfg_we) m_cfg = int'(cfg_wdata);
        end
        @(negedge clk);
        clr_in();
    endtask

    task automatic view_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            cyc(tag);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_int = 0; m_pend = 0; m_err = 0; m_tc = 0; m_ph = 0; m_cfg = 7;
        clr_in();
        rst = 1;
        @(negedge clk);
        rst = 1; @(posedge clk); @(negedge clk);
        rst = 1; @(posedge clk); @(negedge clk);
        clr_in();
        // R8 reset state: int 0, status 0, cfg 07, irq low
        view_all("R8");

        // R1 / R2: bus service then function complete accumulate
        cause_in = 3'b001; cyc("R1");
        rd_sel = 0; cyc("R1");
        cause_in = 3'b010; rd_sel = 0; cyc("R2");
        cause_in = 3'b100; rd_sel = 1; cyc("R2");
        rd_sel = 0; cyc("R2");

        // R5 / R6 / R4 setup: phase command, tc, error
        phase_set = 1; phase_code = 3'd2; tc_hit = 1; err_set = 1; rd_sel = 1; cyc("R5");
        rd_sel = 1; cyc("R6");
        // R3: read interrupt reg clears it, irq low afterwards
        rd_en = 1; rd_sel = 0; cyc("R3");
        rd_sel = 0; cyc("R3");
        // R4: status keeps tc and phase, pending/error gone
        rd_sel = 1; cyc("R4");

        // R9: cause colliding with clear-on-read survives
        cause_in = 3'b001; cyc("R9");
        rd_en = 1; rd_sel = 0; cause_in = 3'b100; err_set = 1; cyc("R9");
        rd_sel = 0; cyc("R9");
        rd_sel = 1; cyc("R9");

        // R5: every phase code, other status bits untouched
        for (int p = 0; p < 8; p++) begin
            phase_set = 1; phase_code = 3'(p); rd_sel = 1; cyc("R5");
        end
        rd_sel = 1; cyc("R5");

        // R6: clear, then simultaneous hit and clear ends set, no irq raised
        rd_en = 1; rd_sel = 0; cyc("R6");
        tc_clr = 1; rd_sel = 1; cyc("R6");
        tc_hit = 1; tc_clr = 1; rd_sel = 1; cyc("R6");
        rd_sel = 1; cyc("R6");

        // R7: bus reset reported with default cfg (bit6 clear)
        bus_rst_cmd = 1; rd_sel = 0; cyc("R7");
        rd_sel = 0; cyc("R7");
        rd_en = 1; rd_sel = 0; cyc("R7");
        // R10: write cfg report-disable; read of cfg has no side effect
        cfg_we = 1; cfg_wdata = 8'h47; rd_sel = 2; cyc("R10");
        rd_en = 1; rd_sel = 2; cyc("R10");
        rd_en = 1; rd_sel = 1; cyc("R10");
        rd_en = 1; rd_sel = 3; cyc("R10");
        // R7: suppressed bus reset leaves int and irq
        bus_rst_cmd = 1; rd_sel = 0; cyc("R7");
        rd_sel = 0; cyc("R7");
        // R7: held value counts: write cfg to 0 together with bus reset, still muted
        bus_rst_cmd = 1; cfg_we = 1; cfg_wdata = 8'h00; rd_sel = 0; cyc("R7");
        rd_sel = 0; cyc("R7");
        // now cfg bit6 clear: write 0x40 with bus reset, reported
        bus_rst_cmd = 1; cfg_we = 1; cfg_wdata = 8'h40; rd_sel = 0; cyc("R7");
        rd_sel = 0; cyc("R7");
        rd_sel = 2; cyc("R10");

        // R8: chip reset command overrides same-cycle inputs
        cause_in = 3'b011; err_set = 1; phase_set = 1; phase_code = 3'd7; tc_hit = 1;
        soft_rst_cmd = 1; rd_sel = 1; cyc("R8");
        view_all("R8");

        // R1: pending holds without read
        cause_in = 3'b100; cyc("R1");
        for (int k = 0; k < 3; k++) begin
            rd_sel = 1; cyc("R1");
        end

        // R8: hard reset
        rst = 1; cause_in = 3'b001; cyc("R8");
        view_all("R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule